// File: doc/BRIEF.md
# Duplicated-Copy Triple-Error-Correcting Link Decoder

This block receives a 77-wire protected word on an on-chip link and recovers the 32-bit payload, even when up to three of the 77 wires arrive flipped. The sender protects the payload with a (38,32) single-error-correcting Hamming code. It sends that 38-bit result twice, as copy A and copy B. It also adds one extra wire, P0, which carries the even parity of copy A. The receiver forms a syndrome for each copy and a parity over copy A. A fixed decision tree then picks the copy that holds at most one error. That copy is corrected by one shared single-error-correcting stage. A matching combinational encoder module is part of the project.

Words enter and leave on valid/ready streams, with a single output register between them. A word is accepted on a rising clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being emptied in the same cycle. While `out_valid` is high and `out_ready` is low, the output holds its value and no new word is accepted.

Top module: `tec_decoder`

## Requirements
- R1: Codeword layout. Bits [37:0] are copy A, bits [75:38] are copy B (an exact duplicate), and bit 76 is P0, the XOR of the 38 copy-A bits. Within a copy, bit i stands for Hamming position i+1. The check bits sit at positions 1, 2, 4, 8, 16 and 32. Data bits 0..31 fill the remaining positions 3, 5, 6, 7, 9, ... 38 in rising order. Each check bit makes the XOR of the positions of all set bits equal to zero. The encoder produces exactly this word.
- R2: An error-free codeword yields its original 32-bit data, with `out_fixed` low.
- R3: A codeword with any single bit flipped, among all 77 bits, yields the exact original data.
- R4: A codeword with any two distinct bits flipped yields the exact original data.
- R5: A codeword with any three distinct bits flipped yields the exact original data.
- R6: `out_fixed` is high exactly when the copy handed to the correction stage had a nonzero syndrome. With three or fewer errors, this happens exactly when both copy A and copy B contain at least one flipped bit. Errors confined to one copy, to P0, or to one copy plus P0 leave it low.
- R7: `in_ready` equals (not `out_valid`) or `out_ready`. A word accepted on one edge appears on `out_data`/`out_fixed` with `out_valid` high right after that edge. An output taken with no new word accepted leaves `out_valid` low.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_fixed` stay unchanged.
- R9: While `rst_n` is low, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Decoder can take a word this cycle |
| in_code | input | 77 | Received protected word (layout per R1) |
| out_valid | output | 1 | Decoded word present |
| out_ready | input | 1 | Consumer takes the decoded word |
| out_data | output | 32 | Recovered payload |
| out_fixed | output | 1 | The selected copy needed a bit corrected |

## Verification
The decoder is tried with clean codewords, then with every single-bit flip across all 77 wires on two payloads, then with random two-bit and three-bit flip sets drawn from the whole word. Each pattern is checked for exact payload recovery. The single flips separate errors in copy A, copy B and P0, because each of these takes a different branch of the copy choice. Multi-bit sets that hit both copies are separated from sets confined to one copy through the expected `out_fixed` value. A stalled-consumer sequence shows that the output holds and input acceptance stops until the consumer returns.

// File: rtl/tec_pkg.sv
package tec_pkg;
  localparam int DATA_W = 32;
  localparam int SYN_W  = 6;
  localparam int COPY_W = DATA_W + SYN_W;
  localparam int CODE_W = 2 * COPY_W + 1;

  typedef enum logic {
    PICK_A = 1'b0,
    PICK_B = 1'b1
  } pick_t;
endpackage

// File: rtl/tec_encoder.sv
module tec_encoder
  import tec_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int SW = SYN_W,
  localparam int CPW = DW + SW,
  localparam int CDW = 2 * CPW + 1
) (
  input  logic [DW-1:0]  data_i,
  output logic [CDW-1:0] code_o
);
  logic [CPW-1:0] word;
  logic [SW-1:0]  chk;

  always_comb begin
    int j;
    j = 0;
    word = '0;
    for (int p = 1; p <= CPW; p++) begin
      if ((p & (p - 1)) != 0) begin
        word[p-1] = data_i[j];
        j++;
      end
    end
    chk = '0;
    for (int p = 1; p <= CPW; p++) begin
      if (word[p-1]) chk = chk ^ SW'(p);
    end
    for (int k = 0; k < SW; k++) begin
      if ((1 << k) <= CPW) word[(1 << k) - 1] = chk[k];
    end
    code_o = {^word, word, word};
  end
endmodule

// File: rtl/tec_copy_check.sv
module tec_copy_check
  import tec_pkg::*;
#(
  parameter int CPW = COPY_W,
  parameter int SW  = SYN_W
) (
  input  logic [CPW-1:0] copy_i,
  output logic [SW-1:0]  syn_o
);
  always_comb begin
    syn_o = '0;
    for (int p = 1; p <= CPW; p++) begin
      if (copy_i[p-1]) syn_o = syn_o ^ SW'(p);
    end
  end
endmodule

// File: rtl/tec_copy_select.sv
module tec_copy_select
  import tec_pkg::*;
#(
  parameter int SW = SYN_W
) (
  input  logic [SW-1:0] syn_a_i,
  input  logic [SW-1:0] syn_b_i,
  input  logic          par_a_i,
  input  logic          p0_i,
  output pick_t         pick_o
);
  logic a_dirty, b_clean, odd_side_a;

  assign a_dirty    = |syn_a_i;
  assign b_clean    = ~|syn_b_i;
  assign odd_side_a = par_a_i ^ p0_i;

  always_comb begin
    if (a_dirty) begin
      // even count on A plus P0 means two hits there: B has at most one
      if (!odd_side_a)  pick_o = PICK_B;
      else if (b_clean) pick_o = PICK_B;
      else              pick_o = PICK_A;
    end else begin
      // zero syndrome with even count means A is intact
      if (!odd_side_a)  pick_o = PICK_A;
      else if (b_clean) pick_o = PICK_B;
      else              pick_o = PICK_A;
    end
  end
endmodule

// File: rtl/tec_sec_fix.sv
module tec_sec_fix
  import tec_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int SW = SYN_W,
  localparam int CPW = DW + SW
) (
  input  logic [CPW-1:0] copy_i,
  input  logic [SW-1:0]  syn_i,
  output logic [DW-1:0]  data_o,
  output logic           fixed_o
);
  always_comb begin
    int j;
    j = 0;
    data_o = '0;
    for (int p = 1; p <= CPW; p++) begin
      if ((p & (p - 1)) != 0) begin
        data_o[j] = copy_i[p-1] ^ (syn_i == SW'(p));
        j++;
      end
    end
    fixed_o = |syn_i;
  end
endmodule

// File: rtl/tec_decoder.sv
module tec_decoder
  import tec_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int SW = SYN_W,
  localparam int CPW = DW + SW,
  localparam int CDW = 2 * CPW + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [CDW-1:0] in_code,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [DW-1:0]  out_data,
  output logic           out_fixed
);
  logic [CPW-1:0] copies [2];
  logic [SW-1:0]  syns   [2];
  logic           par_a, p0;
  pick_t          pick;
  logic [CPW-1:0] sel_copy;
  logic [SW-1:0]  sel_syn;
  logic [DW-1:0]  fix_data;
  logic           fix_flag;
  logic           take;

  assign p0 = in_code[CDW-1];

  for (genvar c = 0; c < 2; c++) begin : g_copy
    assign copies[c] = in_code[c*CPW +: CPW];
    tec_copy_check #(.CPW(CPW), .SW(SW)) u_chk (
      .copy_i (copies[c]),
      .syn_o  (syns[c])
    );
  end

  assign par_a = ^copies[0];

  tec_copy_select #(.SW(SW)) u_sel (
    .syn_a_i (syns[0]),
    .syn_b_i (syns[1]),
    .par_a_i (par_a),
    .p0_i    (p0),
    .pick_o  (pick)
  );

  assign sel_copy = (pick == PICK_B) ? copies[1] : copies[0];
  assign sel_syn  = (pick == PICK_B) ? syns[1]   : syns[0];

  tec_sec_fix #(.DW(DW), .SW(SW)) u_fix (
    .copy_i  (sel_copy),
    .syn_i   (sel_syn),
    .data_o  (fix_data),
    .fixed_o (fix_flag)
  );

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_fixed <= 1'b0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_data  <= fix_data;
      out_fixed <= fix_flag;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/tec_decoder_chk.sv
module tec_decoder_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_data,
  input logic          out_fixed
);
  p_reset_idle_r9: assert property (@(posedge clk) !rst_n |=> !out_valid);

  p_empty_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  p_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  p_drain_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !in_valid |=> !out_valid);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_fixed));
endmodule

bind tec_decoder tec_decoder_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_fixed (out_fixed)
);

// File: tb/tec_decoder_tb.sv
module tec_decoder_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [76:0] in_code;
  logic        out_valid;
  logic        out_ready;
  logic [31:0] out_data;
  logic        out_fixed;
  logic [31:0] enc_data;
  logic [76:0] enc_code;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  tec_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_code(in_code), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_fixed(out_fixed)
  );

  tec_encoder u_enc (.data_i(enc_data), .code_o(enc_code));

  function automatic logic [76:0] ref_encode(logic [31:0] d);
    logic [37:0] w;
    int j;
    w = '0;
    j = 0;
    for (int p = 1; p <= 38; p++)
      if ((p & (p - 1)) != 0) begin w[p-1] = d[j]; j++; end
    for (int k = 0; k < 6; k++) begin
      logic acc;
      acc = 1'b0;
      for (int p = 1; p <= 38; p++)
        if (((p >> k) & 1) == 1 && (p & (p - 1)) != 0) acc = acc ^ w[p-1];
      w[(1 << k) - 1] = acc;
    end
    return {^w, w, w};
  endfunction

  task automatic check(input logic ok, input string req,
                       input logic [76:0] act, input logic [76:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [76:0] cw, input logic [31:0] d,
                      input logic fx, input string req);
    @(negedge clk);
    in_valid = 1'b1;
    in_code  = cw;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid == 1'b1, "R7", 77'(out_valid), 77'd1);
    check(out_data == d, req, 77'(out_data), 77'(d));
    check(out_fixed == fx, "R6", 77'(out_fixed), 77'(fx));
  endtask

  task automatic send_err(input logic [31:0] d, input logic [76:0] e, input string req);
    logic fx;
    fx = (|e[37:0]) && (|e[75:38]);
    send(ref_encode(d) ^ e, d, fx, req);
  endtask

  initial begin
    logic [31:0] seed_val;
    seed_val = $urandom(32'h5eed_1234);
    rst_n = 1'b0; in_valid = 1'b0; in_code = '0; out_ready = 1'b1; enc_data = '0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R9", 77'(out_valid), 77'd0);
    check(in_ready == 1'b1, "R9", 77'(in_ready), 77'd1);
    rst_n = 1'b1;

    // R1: encoder against bench encoding
    for (int i = 0; i < 24; i++) begin
      @(negedge clk);
      enc_data = (i == 0) ? 32'h0 : (i == 1) ? 32'hFFFF_FFFF : (i == 2) ? 32'h0000_0001 : $urandom;
      #1;
      check(enc_code == ref_encode(enc_data), "R1", enc_code, ref_encode(enc_data));
    end

    // R2: clean words
    send(ref_encode(32'h0), 32'h0, 1'b0, "R2");
    send(ref_encode(32'hFFFF_FFFF), 32'hFFFF_FFFF, 1'b0, "R2");
    send(ref_encode(32'h8000_0001), 32'h8000_0001, 1'b0, "R2");
    for (int i = 0; i < 8; i++) begin
      logic [31:0] d;
      d = $urandom;
      send(ref_encode(d), d, 1'b0, "R2");
    end

    // R3: every single flip across all 77 wires
    for (int w = 0; w < 2; w++) begin
      logic [31:0] d;
      d = (w == 0) ? 32'hA5C3_0F96 : 32'h0000_0000;
      for (int b = 0; b < 77; b++) send_err(d, 77'd1 << b, "R3");
    end

    // R6 directed: hits in both copies, and P0 only
    send_err(32'h1357_9BDF, (77'd1 << 3) | (77'd1 << 40), "R6");
    send_err(32'h1357_9BDF, 77'd1 << 76, "R6");
    send_err(32'h1357_9BDF, (77'd1 << 0) | (77'd1 << 1) | (77'd1 << 76), "R6");

    // R4: random two-bit flips
    for (int i = 0; i < 400; i++) begin
      int a, b;
      a = int'($urandom % 77);
      do b = int'($urandom % 77); while (b == a);
      send_err($urandom, (77'd1 << a) | (77'd1 << b), "R4");
    end

    // R5: random three-bit flips, plus triples forming a copy-A codeword
    for (int i = 0; i < 400; i++) begin
      int a, b, c;
      a = int'($urandom % 77);
      do b = int'($urandom % 77); while (b == a);
      do c = int'($urandom % 77); while (c == a || c == b);
      send_err($urandom, (77'd1 << a) | (77'd1 << b) | (77'd1 << c), "R5");
    end
    send_err(32'hDEAD_BEEF, (77'd1 << 0) | (77'd1 << 1) | (77'd1 << 2), "R5");
    send_err(32'hDEAD_BEEF, (77'd1 << 38) | (77'd1 << 39) | (77'd1 << 40), "R5");

    // R7/R8: stalled consumer
    @(negedge clk);
    out_ready = 1'b0;
    in_valid  = 1'b1;
    in_code   = ref_encode(32'h1111_2222);
    @(negedge clk);
    check(out_valid == 1'b1, "R7", 77'(out_valid), 77'd1);
    check(in_ready == 1'b0, "R7", 77'(in_ready), 77'd0);
    in_code = ref_encode(32'h3333_4444);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(out_valid == 1'b1, "R8", 77'(out_valid), 77'd1);
      check(out_data == 32'h1111_2222, "R8", 77'(out_data), 77'h1111_2222);
    end
    out_ready = 1'b1;
    #1;
    check(in_ready == 1'b1, "R7", 77'(in_ready), 77'd1);
    @(negedge clk);
    in_valid = 1'b0;
    check(out_data == 32'h3333_4444, "R7", 77'(out_data), 77'h3333_4444);
    @(negedge clk);
    check(out_valid == 1'b0, "R7", 77'(out_valid), 77'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule